// File: doc/BRIEF.md
# Parallel Port Manual Override Controller

This block is the diagnostic override logic of a parallel port controller. Software reaches it through a small synchronous register bus. From there it can take direct ownership of the 8-bit bidirectional data bus and of the five output control lines. It cannot be used to move data. Its purpose is pin-level diagnostics. The block drives the pad signals: the data to drive, the single tristate enable for the data bus, and the control line outputs. It also returns the sampled pin values through a register read.

A four-state machine tracks the interface mode. The states are `ST_COMPAT` (compatibility), `ST_EPP` (enhanced), `ST_EXT` (extended) and `ST_MANUAL`. The transitions are:

- From `ST_COMPAT`, a control write with the manual bit set goes to `ST_MANUAL`. A control write without it follows the mode field: `ST_COMPAT`, `ST_EPP` or `ST_EXT`.
- From `ST_EPP` or `ST_EXT`, a control write follows the mode field, and the manual bit is dropped.
- From `ST_MANUAL`, a control write with the manual bit clear returns to `ST_COMPAT`. A control write with the manual bit set stays in `ST_MANUAL`, whatever the mode field holds.
- With no control write, the state holds.

Outside `ST_MANUAL`, a protocol engine owns the two upper control lines. Here that engine is the `proto_ctl_i` input. Software keeps only the three lower control lines.

Top module: `ppmo_ctrl`

## Requirements

Register addresses: 0 is the control register, 1 is the manual data register, 2 is the output-value register, and 3 is unused.

Control register bits: bit 7 is the manual bit, bits 5:4 are the mode field (00 compat, 01 EPP, 10 or 11 extended), bit 1 is the direction bit (1 = output) and bit 0 is the output-enable bit. All other control bits read as 0.

- R1: After reset, the state is `ST_COMPAT` and all stored bits are 0. The control register and the output-value register both read 0, `pd_oe` is 0, and `ctl_o` equals `{proto_ctl_i, 3'b000}`.
- R2: A control write with bit 7 set enters `ST_MANUAL` only when the current state is `ST_COMPAT`. From `ST_EPP` or `ST_EXT`, bit 7 is ignored and the state follows the mode field.
- R3: When the direction bit is 0, `pd_oe` is 0 whatever the output-enable bit holds.
- R4: In `ST_MANUAL` with the direction bit at 1, `pd_oe` equals the output-enable bit, and `pd_o` equals the manual data register.
- R5: A read of address 1 returns the pin values through a two-flop synchronizer. A pin change made between edges shows after the second rising edge, and not after the first. This holds whenever the state is not `ST_MANUAL` or the direction bit is 0. Otherwise, the read returns the stored manual data value.
- R6: In `ST_MANUAL`, `ctl_o[4:0]` equals output-value register bits 4:0. A read of address 2 returns those 5 bits, with bits 7:5 reading 0.
- R7: Outside `ST_MANUAL`, `ctl_o[2:0]` equals output-value bits 2:0 and `ctl_o[4:3]` equals `proto_ctl_i`.
- R8: A control write that clears bit 7 while in `ST_MANUAL` gives `pd_oe` = 0 and state `ST_COMPAT` from the very next clock edge.
- R9: In `ST_MANUAL`, a control write with bit 7 set keeps `ST_MANUAL`. The mode field of that write is ignored, so the control register reads back mode 00 and bit 7 = 1.
- R10: The control register read reports the manual bit and the mode field from the state (`ST_EXT` reads 10), together with the stored direction and output-enable bits.
- R11: Writes to address 3 change no register, and reads of address 3 return 0.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pd_i | input | 8 | Data bus pin values |
| pd_o | output | 8 | Data bus drive value |
| pd_oe | output | 1 | Data bus driver enable (1 = drive) |
| proto_ctl_i | input | 2 | Protocol engine values for control lines 4:3 |
| ctl_o | output | 5 | Control line outputs |

## Verification

The hardest situation to reach is an attempt to enter manual mode from a non-compatibility mode. Reaching it takes a mode-field write to reach `ST_EPP` or `ST_EXT`, followed by a write that sets the manual bit together with direction and enable. The stimulus then checks both the control readback and `pd_oe` to show the request was dropped. The same run shows that the direction and enable bits stored during that write have no effect on the bus. The exit to `ST_COMPAT` is sampled in the first cycle after the clearing write. The synchronizer latency is probed by changing the pins between edges and reading back after one edge and again after two.

// File: rtl/ppmo_pkg.sv
package ppmo_pkg;

    typedef enum logic [1:0] {
        ST_COMPAT = 2'd0,
        ST_EPP    = 2'd1,
        ST_EXT    = 2'd2,
        ST_MANUAL = 2'd3
    } port_state_e;

    // Control register field positions
    localparam int unsigned CB_MANUAL   = 7;
    localparam int unsigned CB_MODE_LSB = 4;
    localparam int unsigned CB_DIR      = 1;
    localparam int unsigned CB_OE       = 0;

    // Mode field codes
    localparam logic [1:0] MD_COMPAT = 2'b00;
    localparam logic [1:0] MD_EPP    = 2'b01;
    localparam logic [1:0] MD_EXT    = 2'b10;

    // Register addresses
    localparam int unsigned RA_CTRL = 0;
    localparam int unsigned RA_MDAT = 1;
    localparam int unsigned RA_OVAL = 2;

endpackage

// File: rtl/ppmo_mode_fsm.sv
module ppmo_mode_fsm
    import ppmo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic        wr_manual,
    input  logic [1:0]  wr_mode,
    output port_state_e state_o
);

    port_state_e state_q;
    port_state_e state_d;
    port_state_e mode_target;

    // Map the mode field to a non-manual state
    always_comb begin
        unique case (wr_mode)
            MD_COMPAT: mode_target = ST_COMPAT;
            MD_EPP:    mode_target = ST_EPP;
            default:   mode_target = ST_EXT;
        endcase
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            unique case (state_q)
                ST_COMPAT: state_d = wr_manual ? ST_MANUAL : mode_target;
                ST_EPP,
                ST_EXT:    state_d = mode_target;
                ST_MANUAL: state_d = wr_manual ? ST_MANUAL : ST_COMPAT;
                default:   state_d = ST_COMPAT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COMPAT;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // R2: manual entry never happens from the enhanced or extended states
    p_enter_only_compat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EPP || state_q == ST_EXT) |=> (state_q != ST_MANUAL));

    // R9: a write keeping the manual bit holds manual mode
    p_manual_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MANUAL && ctrl_wr && wr_manual) |=> (state_q == ST_MANUAL));

    // R2: the state changes only on a control write
    p_state_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(state_q));

endmodule

// File: rtl/ppmo_sync.sv
module ppmo_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= async_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_q[g-1];
        end
    end

    assign sync_o = stg_q[LAST];

endmodule

// File: rtl/ppmo_regs.sv
module ppmo_regs
    import ppmo_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CTL_W  = 5,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  port_state_e       state,
    input  logic [DATA_W-1:0] pin_sync,
    output logic              ctrl_wr,
    output logic              dir_q,
    output logic              oe_q,
    output logic [DATA_W-1:0] mdat_q,
    output logic [CTL_W-1:0]  oval_q,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(RA_CTRL);
    localparam logic [ADDR_W-1:0] A_MDAT = ADDR_W'(RA_MDAT);
    localparam logic [ADDR_W-1:0] A_OVAL = ADDR_W'(RA_OVAL);

    logic mdat_wr;
    logic oval_wr;
    logic bus_out;
    logic [DATA_W-1:0] ctrl_view;
    logic [DATA_W-1:0] mdat_view;
    logic [DATA_W-1:0] oval_view;

    assign ctrl_wr = we && (addr == A_CTRL);
    assign mdat_wr = we && (addr == A_MDAT);
    assign oval_wr = we && (addr == A_OVAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            oe_q  <= 1'b0;
        end else if (ctrl_wr) begin
            dir_q <= wdata[CB_DIR];
            oe_q  <= wdata[CB_OE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mdat_q <= '0;
        else if (mdat_wr) mdat_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       oval_q <= '0;
        else if (oval_wr) oval_q <= wdata[CTL_W-1:0];
    end

    // Bus direction as seen by the read path
    assign bus_out = (state == ST_MANUAL) && dir_q;

    always_comb begin
        ctrl_view         = '0;
        ctrl_view[CB_DIR] = dir_q;
        ctrl_view[CB_OE]  = oe_q;
        unique case (state)
            ST_COMPAT: ctrl_view[CB_MODE_LSB +: 2] = MD_COMPAT;
            ST_EPP:    ctrl_view[CB_MODE_LSB +: 2] = MD_EPP;
            ST_EXT:    ctrl_view[CB_MODE_LSB +: 2] = MD_EXT;
            ST_MANUAL: ctrl_view[CB_MANUAL]        = 1'b1;
            default:   ctrl_view                   = '0;
        endcase
    end

    assign mdat_view = bus_out ? mdat_q : pin_sync;

    always_comb begin
        oval_view            = '0;
        oval_view[CTL_W-1:0] = oval_q;
    end

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = ctrl_view;
            A_MDAT:  rdata = mdat_view;
            A_OVAL:  rdata = oval_view;
            default: rdata = '0;
        endcase
    end

    // R6: an output-value write lands in the register one edge later
    p_oval_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oval_wr |=> (oval_q == $past(wdata[CTL_W-1:0])));

    // R11: with no write strobe, the stored bits hold
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(mdat_q) && $stable(oval_q) && $stable(dir_q)));

endmodule

// File: rtl/ppmo_drive.sv
module ppmo_drive
    import ppmo_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CTL_W  = 5,
    parameter int unsigned SW_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  port_state_e             state,
    input  logic                    dir_i,
    input  logic                    oe_i,
    input  logic [DATA_W-1:0]       mdat_i,
    input  logic [CTL_W-1:0]        oval_i,
    input  logic [CTL_W-SW_W-1:0]   proto_i,
    output logic [DATA_W-1:0]       pd_o,
    output logic                    pd_oe,
    output logic [CTL_W-1:0]        ctl_o
);

    localparam int unsigned PROTO_W = CTL_W - SW_W;

    // Outputs, decided per state
    always_comb begin
        pd_o = mdat_i;
        unique case (state)
            ST_MANUAL: begin
                pd_oe = dir_i && oe_i;
                ctl_o = oval_i;
            end
            ST_COMPAT,
            ST_EPP,
            ST_EXT: begin
                pd_oe = 1'b0;
                ctl_o = {proto_i, oval_i[SW_W-1:0]};
            end
            default: begin
                pd_oe = 1'b0;
                ctl_o = '0;
            end
        endcase
    end

    // R3: the driver is never on while the direction bit says input
    p_oe_needs_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pd_oe |-> dir_i);

    // R7: a protocol-owned line tracks the engine input outside manual mode
    p_proto_lines_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_MANUAL) |-> (ctl_o[CTL_W-1 -: PROTO_W] == proto_i));

endmodule

// File: rtl/ppmo_ctrl.sv
module ppmo_ctrl
    import ppmo_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CTL_W       = 5,
    parameter int unsigned SW_W        = 3,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_we,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [DATA_W-1:0]     pd_i,
    output logic [DATA_W-1:0]     pd_o,
    output logic                  pd_oe,
    input  logic [CTL_W-SW_W-1:0] proto_ctl_i,
    output logic [CTL_W-1:0]      ctl_o
);

    port_state_e       state;
    logic              ctrl_wr;
    logic              dir_q;
    logic              oe_q;
    logic [DATA_W-1:0] mdat_q;
    logic [CTL_W-1:0]  oval_q;
    logic [DATA_W-1:0] pin_sync;

    ppmo_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .wr_manual (reg_wdata[CB_MANUAL]),
        .wr_mode   (reg_wdata[CB_MODE_LSB +: 2]),
        .state_o   (state)
    );

    ppmo_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pd_i),
        .sync_o  (pin_sync)
    );

    ppmo_regs #(.DATA_W(DATA_W), .CTL_W(CTL_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .we       (reg_we),
        .wdata    (reg_wdata),
        .state    (state),
        .pin_sync (pin_sync),
        .ctrl_wr  (ctrl_wr),
        .dir_q    (dir_q),
        .oe_q     (oe_q),
        .mdat_q   (mdat_q),
        .oval_q   (oval_q),
        .rdata    (reg_rdata)
    );

    ppmo_drive #(.DATA_W(DATA_W), .CTL_W(CTL_W), .SW_W(SW_W)) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .state   (state),
        .dir_i   (dir_q),
        .oe_i    (oe_q),
        .mdat_i  (mdat_q),
        .oval_i  (oval_q),
        .proto_i (proto_ctl_i),
        .pd_o    (pd_o),
        .pd_oe   (pd_oe),
        .ctl_o   (ctl_o)
    );

    // R8: leaving manual mode releases the bus at the next edge
    p_leave_tristate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MANUAL && ctrl_wr && !reg_wdata[CB_MANUAL])
            |=> (!pd_oe && state == ST_COMPAT));

endmodule

// File: tb/sim_ppmo_ctrl.sv
`timescale 1ns/100ps
module sim_ppmo_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pd_i = '0;
    logic [7:0] pd_o;
    logic       pd_oe;
    logic [1:0] proto_ctl_i = 2'b10;
    logic [4:0] ctl_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Scoreboard: kind 0 = read data, 1 = pd_oe, 2 = pd_o, 3 = ctl_o
    int         kq[$];
    logic [7:0] eq[$];
    string      tq[$];
    event       sb_ev;

    always #2.5 clk = ~clk;

    ppmo_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .pd_i        (pd_i),
        .pd_o        (pd_o),
        .pd_oe       (pd_oe),
        .proto_ctl_i (proto_ctl_i),
        .ctl_o       (ctl_o)
    );

    // Monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(sb_ev);
            while (kq.size() > 0) begin
                int k;
                logic [7:0] e;
                logic [7:0] act;
                string t;
                k = kq.pop_front();
                e = eq.pop_front();
                t = tq.pop_front();
                case (k)
                    0:       act = reg_rdata;
                    1:       act = {7'b0, pd_oe};
                    2:       act = pd_o;
                    default: act = {3'b0, ctl_o};
                endcase
                checks++;
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s: actual %02h expected %02h", t, act, e);
                end
            end
        end
    end

    task automatic expect_item(input int kind, input logic [7:0] exp, input string tag);
        #0.1;
        kq.push_back(kind);
        eq.push_back(exp);
        tq.push_back(tag);
        -> sb_ev;
        #0.1;
    endtask

    task automatic chk_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a;
        expect_item(0, exp, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_rd(2'd0, 8'h00, "R1 ctrl after reset");
        chk_rd(2'd2, 8'h00, "R1 oval after reset");
        expect_item(1, 8'h00, "R1 pd_oe after reset");
        expect_item(3, 8'h10, "R1 ctl_o after reset");

        // R7: software owns the lower three lines only
        wr(2'd2, 8'h0A);
        expect_item(3, 8'h12, "R7 ctl_o compat with proto 10");
        proto_ctl_i = 2'b01;
        expect_item(3, 8'h0A, "R7 ctl_o follows proto 01");
        chk_rd(2'd2, 8'h0A, "R6 oval readback");

        // R5: two-edge synchronizer latency
        @(negedge clk);
        pd_i = 8'hA5;
        chk_rd(2'd1, 8'h00, "R5 pins before any edge");
        @(negedge clk);
        chk_rd(2'd1, 8'h00, "R5 pins after one edge");
        @(negedge clk);
        chk_rd(2'd1, 8'hA5, "R5 pins after two edges");

        // R2 / R10: enhanced mode, manual request ignored
        wr(2'd0, 8'h10);
        chk_rd(2'd0, 8'h10, "R10 ctrl reads EPP");
        wr(2'd0, 8'h90);
        chk_rd(2'd0, 8'h10, "R2 manual ignored from EPP");
        expect_item(3, 8'h0A, "R7 ctl_o in EPP");
        wr(2'd0, 8'h20);
        chk_rd(2'd0, 8'h20, "R10 ctrl reads EXT");
        wr(2'd0, 8'hA3);
        chk_rd(2'd0, 8'h23, "R2 manual ignored from EXT");
        expect_item(1, 8'h00, "R2 bus not driven in EXT");
        wr(2'd0, 8'h30);
        chk_rd(2'd0, 8'h20, "R10 mode 11 reads as EXT");

        // Back to compat, then manual with direction = input
        wr(2'd0, 8'h00);
        chk_rd(2'd0, 8'h00, "R10 ctrl reads compat");
        wr(2'd0, 8'h81);
        chk_rd(2'd0, 8'h81, "R2 manual entered from compat");
        expect_item(1, 8'h00, "R3 oe ignored with dir=0");
        expect_item(3, 8'h0A, "R6 manual ctl_o from oval");
        wr(2'd2, 8'h1F);
        expect_item(3, 8'h1F, "R6 manual ctl_o all five");
        chk_rd(2'd1, 8'hA5, "R5 manual input reads pins");
        wr(2'd1, 8'h3C);
        chk_rd(2'd1, 8'hA5, "R5 dir=0 still reads pins");

        // R4: output direction
        wr(2'd0, 8'h82);
        expect_item(1, 8'h00, "R4 dir=1 oe=0 floats");
        chk_rd(2'd1, 8'h3C, "R5 dir=1 reads stored data");
        wr(2'd0, 8'h83);
        expect_item(1, 8'h01, "R4 dir=1 oe=1 drives");
        expect_item(2, 8'h3C, "R4 pd_o from manual data");

        // R9: mode field ignored in manual
        wr(2'd0, 8'h93);
        chk_rd(2'd0, 8'h83, "R9 mode ignored in manual");
        expect_item(1, 8'h01, "R9 bus still driven");

        // R8: leave manual, bus released at the first edge
        wr(2'd0, 8'h03);
        expect_item(1, 8'h00, "R8 pd_oe off one edge after exit");
        chk_rd(2'd0, 8'h03, "R8 state back to compat");
        expect_item(3, 8'h0F, "R7 ctl_o after exit");

        // R11: unused address
        wr(2'd3, 8'hFF);
        chk_rd(2'd3, 8'h00, "R11 unused reads zero");
        chk_rd(2'd0, 8'h03, "R11 ctrl unchanged");
        chk_rd(2'd2, 8'h1F, "R11 oval unchanged");
        wr(2'd0, 8'h83);
        chk_rd(2'd1, 8'h3C, "R11 manual data unchanged");
        wr(2'd2, 8'hE5);
        chk_rd(2'd2, 8'h05, "R6 upper oval bits read zero");

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk_rd(2'd0, 8'h00, "R1 ctrl after second reset");
        expect_item(1, 8'h00, "R1 pd_oe after second reset");
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule